// File: doc/BRIEF.md
# Evenly Spread Oscillator Setting Selector

This block picks, cycle by cycle, between two neighbouring settings of a digitally tuned oscillator. The two settings are a base code k and k+1. Each clock produces one select bit. Over a window of PERIOD enabled clocks the select bit is high on exactly m of them. The result is an average frequency between the two settings, and the control loop sets m to a resolution of 1/PERIOD.

The high cycles are not gathered into one run. A modulus-PERIOD phase accumulator adds m on every enabled clock, and the select bit is its overflow. This places each high cycle where the accumulated phase passes a whole step, so the gaps between high cycles differ by at most one clock. The cycle-to-cycle period variation therefore never exceeds the difference between the two settings.

New values of m and k take effect only at the start of a window. The accumulator residue carries across the change, so the phase does not jump.

Top module: `pdm_freq_sel`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises with en low, sel_o is 0 and setting_o is 0.
- R2: Over every window of PERIOD enabled clocks, the count of cycles with sel_o high equals the m that was captured for that window.
- R3: Count the enabled clocks from the end of reset, and let P be the running sum of the captured m values up to and including the current clock. Then sel_o is floor(P/PERIOD) - floor((P-m)/PERIOD). Within one window, the gaps between high cycles therefore differ by at most one clock.
- R4: setting_o equals the captured base k plus sel_o, with a result width of KW+1 so that it never wraps.
- R5: When the captured m is 0, sel_o stays 0 and setting_o equals k.
- R6: When the captured count_i is PERIOD or larger, m is taken as PERIOD, and sel_o is 1 on every enabled clock.
- R7: count_i and base_i are captured only on the first enabled clock of a window. A change in the middle of a window has no effect until the next window begins.
- R8: The accumulator residue is kept across a change of m, so R3 holds across windows with different m.
- R9: On a clock with en low, sel_o, setting_o and all internal state hold their values, and the window position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the modulator on this clock |
| count_i | input | CW = $clog2(PERIOD+1) | Requested high count m per window |
| base_i | input | KW | Base oscillator setting k |
| sel_o | output | 1 | Select bit: 0 picks k, 1 picks k+1 |
| setting_o | output | KW+1 | Setting word, k plus sel_o |

## Verification
The bench builds the block with PERIOD=10 and KW=4. A period that is not a power of two exercises the subtract-on-overflow path, which a plain binary wrap would hide. The 4-bit count input can also carry requests of 11 to 15, which must saturate to PERIOD. With k=15 the setting reaches 16, which confirms the extra bit on the setting word. A running phase model across windows with different m checks residue continuity, the placement of high cycles, and the capture at window boundaries.

// File: rtl/pdm_freq_sel.sv
module pdm_freq_sel #(
  parameter int PERIOD = 16,
  parameter int KW     = 8,
  localparam int CW    = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] count_i,
  input  logic [KW-1:0] base_i,
  output logic          sel_o,
  output logic [KW:0]   setting_o
);

  localparam logic [CW:0]   PER_W  = (CW+1)'(PERIOD);
  localparam logic [CW-1:0] PER_C  = CW'(PERIOD);
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

  logic [CW-1:0] win_q, m_q, acc_q;
  logic [KW-1:0] k_q;

  wire           at_start = (win_q == '0);
  wire [CW-1:0]  m_req    = (count_i > PER_C) ? PER_C : count_i;
  wire [CW-1:0]  m_eff    = at_start ? m_req  : m_q;
  wire [KW-1:0]  k_eff    = at_start ? base_i : k_q;
  wire [CW:0]    sum      = {1'b0, acc_q} + {1'b0, m_eff};
  wire           carry    = (sum >= PER_W);
  wire [CW:0]    wrapped  = carry ? (sum - PER_W) : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q     <= '0;
      m_q       <= '0;
      k_q       <= '0;
      acc_q     <= '0;
      sel_o     <= 1'b0;
      setting_o <= '0;
    end else if (en) begin
      win_q     <= (win_q == LAST_C) ? '0 : win_q + 1'b1;
      m_q       <= m_eff;
      k_q       <= k_eff;
      acc_q     <= wrapped[CW-1:0];
      sel_o     <= carry;
      setting_o <= {1'b0, k_eff} + {{KW{1'b0}}, carry};
    end
  end

endmodule

module pdm_freq_sel_chk #(
  parameter int PERIOD = 16,
  parameter int KW     = 8,
  localparam int CW    = $clog2(PERIOD + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] acc_q,
  input logic [CW-1:0] m_eff,
  input logic          sel_o,
  input logic [KW:0]   setting_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!sel_o && setting_o == '0));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(sel_o) && $stable(setting_o)));

  // R5
  zero_count_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m_eff == '0) |=> !sel_o);

  // R6
  full_count_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m_eff == CW'(PERIOD)) |=> sel_o);

  // R3
  residue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < CW'(PERIOD));

endmodule

bind pdm_freq_sel pdm_freq_sel_chk #(.PERIOD(PERIOD), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .acc_q(acc_q), .m_eff(m_eff),
  .sel_o(sel_o), .setting_o(setting_o)
);

// File: tb/test_pdm_freq_sel.sv
module test_pdm_freq_sel;
  localparam int N  = 10;
  localparam int KW = 4;
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, en = 0;
  logic [CW-1:0] count_i = '0;
  logic [KW-1:0] base_i = '0;
  logic sel_o;
  logic [KW:0] setting_o;

  int checks = 0, failures = 0;
  int phase = 0, wpos = 0, mc = 0, kc = 0, ones = 0;
  bit done = 0;

  // {m, k, windows}
  localparam int VEC [7][3] = '{'{3,5,2}, '{0,7,1}, '{10,2,1}, '{13,4,1},
                                '{7,15,2}, '{1,0,2}, '{9,9,1}};

  pdm_freq_sel #(.PERIOD(N), .KW(KW)) i_pdm_freq_sel (
    .clk(clk), .rst_n(rst_n), .en(en), .count_i(count_i), .base_i(base_i),
    .sel_o(sel_o), .setting_o(setting_o));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    int old, es;
    if (en) begin
      if (wpos == 0) begin
        mc = (int'(count_i) > N) ? N : int'(count_i);
        kc = int'(base_i);
        ones = 0;
      end
      old = phase;
      phase += mc;
      es = phase / N - old / N;
      @(posedge clk); #1;
      check(sel_o == es[0], "R3 sel", sel_o, es);
      check(int'(setting_o) == kc + es, "R4 setting", setting_o, kc + es);
      ones += int'(sel_o);
      wpos = (wpos + 1) % N;
      if (wpos == 0) check(ones == mc, "R2 window count", ones, mc);
    end else begin
      logic s0;
      logic [KW:0] t0;
      s0 = sel_o; t0 = setting_o;
      @(posedge clk); #1;
      check(sel_o == s0 && setting_o == t0, "R9 hold", setting_o, t0);
    end
  endtask

  initial begin
    #800000;
    failures++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk); #1;
    check(!sel_o && setting_o == 0, "R1 reset", setting_o, 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(!sel_o && setting_o == 0, "R1 idle after reset", setting_o, 0);
    en = 1;
    foreach (VEC[v]) begin
      count_i = CW'(VEC[v][0]);
      base_i  = KW'(VEC[v][1]);
      for (int c = 0; c < VEC[v][2] * N; c++) begin
        // R5 R6 R8 covered by m=0, m>=N and m changes here
        tick();
      end
    end
    // R7: mid-window change must wait for the boundary
    count_i = 4; base_i = 3;
    for (int c = 0; c < 4; c++) tick();
    count_i = 8; base_i = 12;
    for (int c = 0; c < 6; c++) tick();
    check(mc == 4, "R7 capture", mc, 4);
    for (int c = 0; c < N; c++) tick();
    // R9: idle clocks with changing inputs
    for (int c = 0; c < 3; c++) begin
      tick();
    end
    en = 0; count_i = 1; base_i = 0;
    for (int c = 0; c < 5; c++) tick();
    en = 1;
    for (int c = 0; c < 2 * N + 3; c++) tick();
    // R1: reset mid-run
    rst_n = 0;
    @(posedge clk); #1;
    check(!sel_o && setting_o == 0, "R1 mid-run reset", setting_o, 0);
    rst_n = 1; phase = 0; wpos = 0;
    count_i = 6; base_i = 1;
    for (int c = 0; c < 2 * N; c++) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule